// File: doc/BRIEF.md
# SHA-256 Schedule Update Unit (second half)

This block completes four consecutive SHA-256 message-schedule words in one operation. It takes three 128-bit vectors, each holding four 32-bit lanes with lane 0 in the least significant bits. The first vector is an accumulator that already holds the earlier schedule terms. The second and third vectors hold message words. A window vector is built by taking the upper three words of the second vector and placing the lowest word of the third vector above them. Each result lane adds three terms modulo 2^32: the small sigma of a source word, the accumulator lane of the same index, and the window lane of the same index.

The two upper result lanes take their sigma input from the two lower result lanes of the same operation. The arithmetic therefore runs as a chain of two steps, and the block splits it across two pipeline registers. Operands enter through a valid/ready handshake, and results leave through a second valid/ready handshake. The latency is fixed and does not depend on operand values.

A separate combinational decoder checks a 32-bit instruction word against the fixed encoding of this operation. It reports either a match or an undefined-instruction condition, and it extracts three 5-bit register indices.

Top module: `sha_sched_upd`

## Requirements
- R1: The sigma of a 32-bit word x is ror(x,17) XOR ror(x,19) XOR (x >> 10), with zeros shifted in at the top.
- R2: The window lanes 0, 1 and 2 are bits 63:32, 95:64 and 127:96 of `msg_a_i`, and window lane 3 is bits 31:0 of `msg_b_i`.
- R3: Result lane 0 uses sigma of `msg_b_i` bits 95:64, and result lane 1 uses sigma of `msg_b_i` bits 127:96.
- R4: Result lane 2 uses sigma of result lane 0, and result lane 3 uses sigma of result lane 1. Lane k of the result occupies bits 32k+31:32k of `out_data_o`.
- R5: Result lane k is the sum of its sigma term, lane k of `acc_i` and window lane k, computed modulo 2^32 with the carry discarded.
- R6: With `feat_en_i` high, `dec_match_o` is 1 exactly when `insn_i[31:21]` = 01011110000 and `insn_i[15:10]` = 011000. `dec_rm_o`, `dec_rn_o` and `dec_rd_o` carry `insn_i[20:16]`, `insn_i[9:5]` and `insn_i[4:0]`.
- R7: With `feat_en_i` low, a word that fits the pattern raises `dec_undef_o` and leaves `dec_match_o` at 0. A word that does not fit the pattern raises neither output.
- R8: An input accepted at a rising edge, with `out_ready_i` held high, makes `out_valid_o` high after the second rising edge that follows and not before. This holds for every operand value.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` holds its value and `out_valid_o` stays high. Results leave in acceptance order, each exactly once.
- R10: While `rst_n` is low, and right after it is released, `out_valid_o` is 0 and `in_ready_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en_i | input | 1 | Feature enable for the decoder |
| insn_i | input | 32 | Instruction word to decode |
| dec_match_o | output | 1 | Instruction matches and the feature is enabled |
| dec_undef_o | output | 1 | Instruction matches but the feature is disabled |
| dec_rm_o | output | 5 | Third-operand register index |
| dec_rn_o | output | 5 | Second-operand register index |
| dec_rd_o | output | 5 | Accumulator/destination register index |
| in_valid_i | input | 1 | Operands valid |
| in_ready_o | output | 1 | Unit can accept operands |
| acc_i | input | 128 | Accumulator vector |
| msg_a_i | input | 128 | Second message vector |
| msg_b_i | input | 128 | Third message vector |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer accepts result |
| out_data_o | output | 128 | Four updated schedule words |

## Verification
The assertions run on every cycle and cover four properties. A stalled result must stay valid and keep its value. The ready output may drop only when a result is waiting. A result may appear only when the first stage was full one cycle before. The decoder must never report a match and an undefined condition at the same time, and it must not report a match while the feature is off.

The arithmetic can only be shown by the bench's scenarios, which compare results against a reference model and against the known schedule words of the message "abc". These scenarios cover the window splice, the chain from the lower lanes into the upper lanes, and carry wrap-around in the sums. The bench scenarios also show the exact two-cycle latency and that random backpressure causes no loss or duplication of results.

// File: rtl/sha_su1_pkg.sv
package sha_su1_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = WORD_W * LANES;
    localparam int HALF_L = LANES / 2;
    localparam int HALF_W = WORD_W * HALF_L;

    localparam int ROT_A = 17;
    localparam int ROT_B = 19;
    localparam int SHR_C = 10;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t ror_w(input word_t x, input int amt);
        return (x >> amt) | (x << (WORD_W - amt));
    endfunction

    function automatic word_t small_sigma(input word_t x);
        return ror_w(x, ROT_A) ^ ror_w(x, ROT_B) ^ (x >> SHR_C);
    endfunction

    typedef struct packed {
        logic              v1;
        logic [HALF_W-1:0] lo_res;
        logic [HALF_W-1:0] acc_hi;
        logic [HALF_W-1:0] win_hi;
        logic              v2;
        logic [VEC_W-1:0]  res;
    } pipe_t;
endpackage

// File: rtl/sha_su1_decode.sv
module sha_su1_decode (
    input  logic [31:0] insn_i,
    input  logic        feat_en_i,
    output logic        match_o,
    output logic        undef_o,
    output logic [4:0]  rm_o,
    output logic [4:0]  rn_o,
    output logic [4:0]  rd_o
);
    localparam logic [10:0] HI_PAT  = 11'b01011110000;
    localparam logic [5:0]  MID_PAT = 6'b011000;

    logic hit;

    always_comb begin
        hit     = (insn_i[31:21] == HI_PAT) && (insn_i[15:10] == MID_PAT);
        match_o = hit && feat_en_i;
        undef_o = hit && !feat_en_i;
        rm_o    = insn_i[20:16];
        rn_o    = insn_i[9:5];
        rd_o    = insn_i[4:0];
    end
endmodule

// File: rtl/sha_su1_halfstep.sv
module sha_su1_halfstep
    import sha_su1_pkg::*;
#(
    parameter int NL = HALF_L
) (
    input  logic [NL*WORD_W-1:0] src_i,
    input  logic [NL*WORD_W-1:0] acc_i,
    input  logic [NL*WORD_W-1:0] win_i,
    output logic [NL*WORD_W-1:0] res_o
);
    for (genvar g = 0; g < NL; g++) begin : g_lane
        always_comb begin
            res_o[g*WORD_W +: WORD_W] = small_sigma(src_i[g*WORD_W +: WORD_W])
                                      + acc_i[g*WORD_W +: WORD_W]
                                      + win_i[g*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/sha_sched_upd.sv
module sha_sched_upd
    import sha_su1_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              feat_en_i,
    input  logic [31:0]       insn_i,
    output logic              dec_match_o,
    output logic              dec_undef_o,
    output logic [4:0]        dec_rm_o,
    output logic [4:0]        dec_rn_o,
    output logic [4:0]        dec_rd_o,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [VEC_W-1:0]  acc_i,
    input  logic [VEC_W-1:0]  msg_a_i,
    input  logic [VEC_W-1:0]  msg_b_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [VEC_W-1:0]  out_data_o
);
    pipe_t p_d, p_q;

    logic [VEC_W-1:0]  win;
    logic [HALF_W-1:0] lo_calc, hi_calc;
    logic              s2_free, s2_take, in_fire;

    sha_su1_decode u_dec (
        .insn_i    (insn_i),
        .feat_en_i (feat_en_i),
        .match_o   (dec_match_o),
        .undef_o   (dec_undef_o),
        .rm_o      (dec_rm_o),
        .rn_o      (dec_rn_o),
        .rd_o      (dec_rd_o)
    );

    assign win = {msg_b_i[WORD_W-1:0], msg_a_i[VEC_W-1:WORD_W]};

    sha_su1_halfstep #(.NL(HALF_L)) u_lo (
        .src_i (msg_b_i[VEC_W-1:HALF_W]),
        .acc_i (acc_i[HALF_W-1:0]),
        .win_i (win[HALF_W-1:0]),
        .res_o (lo_calc)
    );

    sha_su1_halfstep #(.NL(HALF_L)) u_hi (
        .src_i (p_q.lo_res),
        .acc_i (p_q.acc_hi),
        .win_i (p_q.win_hi),
        .res_o (hi_calc)
    );

    always_comb begin
        p_d     = p_q;
        s2_free = !p_q.v2 || out_ready_i;
        s2_take = p_q.v1 && s2_free;
        in_fire = in_valid_i && (!p_q.v1 || s2_free);

        if (s2_take) begin
            p_d.v2  = 1'b1;
            p_d.res = {hi_calc, p_q.lo_res};
        end else if (out_ready_i) begin
            p_d.v2 = 1'b0;
        end

        if (in_fire) begin
            p_d.v1     = 1'b1;
            p_d.lo_res = lo_calc;
            p_d.acc_hi = acc_i[VEC_W-1:HALF_W];
            p_d.win_hi = win[VEC_W-1:HALF_W];
        end else if (s2_take) begin
            p_d.v1 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign in_ready_o  = !p_q.v1 || s2_free;
    assign out_valid_o = p_q.v2;
    assign out_data_o  = p_q.res;

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    assert_ready_only_blocked_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready_o |-> (out_valid_o && !out_ready_i));

    assert_result_follows_stage1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> $past(p_q.v1));

    assert_decode_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_match_o && dec_undef_o));

    assert_match_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_match_o |-> feat_en_i);
endmodule

// File: tb/test_sha_sched_upd.sv
`timescale 1ns/100ps
module test_sha_sched_upd;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         feat_en_i = 1'b1;
    logic [31:0]  insn_i = '0;
    logic         dec_match_o, dec_undef_o;
    logic [4:0]   dec_rm_o, dec_rn_o, dec_rd_o;
    logic         in_valid_i = 1'b0;
    logic         in_ready_o;
    logic [127:0] acc_i = '0, msg_a_i = '0, msg_b_i = '0;
    logic         out_valid_o;
    logic         out_ready_i = 1'b1;
    logic [127:0] out_data_o;

    int checks = 0;
    int fails = 0;
    int sent = 0;
    int got = 0;
    bit bp_en = 1'b0;
    bit done = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    logic [127:0] exp_q[$];
    string        tag_q[$];
    string        cur_tag = "R5";

    always #2.5 clk = ~clk;

    sha_sched_upd i_sha_sched_upd (.*);

    function automatic [31:0] s1(input [31:0] x);
        logic [63:0] dd;
        dd = {x, x};
        return dd[48:17] ^ dd[50:19] ^ (x >> 10);
    endfunction

    function automatic [127:0] model(input [127:0] a, input [127:0] b, input [127:0] c);
        logic [31:0] t0, t1, t2, t3, r0, r1, r2, r3;
        t0 = b[63:32];
        t1 = b[95:64];
        t2 = b[127:96];
        t3 = c[31:0];
        r0 = s1(c[95:64])  + a[31:0]   + t0;
        r1 = s1(c[127:96]) + a[63:32]  + t1;
        r2 = s1(r0)        + a[95:64]  + t2;
        r3 = s1(r1)        + a[127:96] + t3;
        return {r3, r2, r1, r0};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic send(input string tag, input [127:0] a, input [127:0] b, input [127:0] c);
        bit rdy;
        rdy = 1'b0;
        while (!rdy) begin
            @(negedge clk);
            in_valid_i = 1'b1;
            acc_i = a;
            msg_a_i = b;
            msg_b_i = c;
            cur_tag = tag;
            #2;
            rdy = in_ready_o;
            @(posedge clk);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    // scoreboard monitor
    bit           stall_prev = 1'b0;
    logic [127:0] held = '0;
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (stall_prev) begin
                    check("R9 hold valid", {127'd0, out_valid_o}, 128'd1);
                    check("R9 hold data", out_data_o, held);
                end
                stall_prev = out_valid_o && !out_ready_i;
                held = out_data_o;
                if (out_valid_o && out_ready_i) begin
                    got++;
                    if (exp_q.size() == 0) begin
                        check("R9 unexpected result", out_data_o, 128'hx);
                    end else begin
                        check(tag_q.pop_front(), out_data_o, exp_q.pop_front());
                    end
                end
                if (in_valid_i && in_ready_o) begin
                    sent++;
                    exp_q.push_back(model(acc_i, msg_a_i, msg_b_i));
                    tag_q.push_back(cur_tag);
                end
            end
        end
    end

    // backpressure driver
    initial begin
        forever begin
            @(negedge clk);
            step_lfsr();
            out_ready_i = bp_en ? lfsr[3] : 1'b1;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic [31:0] enc(input [4:0] rm, input [4:0] rn, input [4:0] rd);
        return {11'b01011110000, rm, 6'b011000, rn, rd};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R10 valid in reset", {127'd0, out_valid_o}, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 valid after reset", {127'd0, out_valid_o}, 128'd0);
        check("R10 ready after reset", {127'd0, in_ready_o}, 128'd1);

        // decoder
        feat_en_i = 1'b1;
        insn_i = enc(5'd17, 5'd9, 5'd30);
        #1;
        check("R6 match", {126'd0, dec_match_o, dec_undef_o}, 128'd2);
        check("R6 fields", {113'd0, dec_rm_o, dec_rn_o, dec_rd_o}, {113'd0, 5'd17, 5'd9, 5'd30});
        insn_i = enc(5'd0, 5'd31, 5'd1);
        #1;
        check("R6 fields b", {113'd0, dec_rm_o, dec_rn_o, dec_rd_o}, {113'd0, 5'd0, 5'd31, 5'd1});
        feat_en_i = 1'b0;
        #1;
        check("R7 undef", {126'd0, dec_match_o, dec_undef_o}, 128'd1);
        insn_i = enc(5'd3, 5'd4, 5'd5) ^ 32'h0000_0400;
        #1;
        check("R7 no pattern disabled", {126'd0, dec_match_o, dec_undef_o}, 128'd0);
        feat_en_i = 1'b1;
        #1;
        check("R6 no pattern enabled", {126'd0, dec_match_o, dec_undef_o}, 128'd0);
        insn_i = enc(5'd3, 5'd4, 5'd5) ^ 32'h8000_0000;
        #1;
        check("R6 top bit differs", {126'd0, dec_match_o, dec_undef_o}, 128'd0);

        // latency, two operand values
        send("R8 latency a", 128'h0, 128'h0, 128'h0);
        idle();
        #1;
        check("R8 not after one edge", {127'd0, out_valid_o}, 128'd0);
        @(negedge clk);
        #1;
        check("R8 valid after two edges", {127'd0, out_valid_o}, 128'd1);
        send("R8 latency b", {4{32'hFFFF_FFFF}}, {4{32'hDEAD_BEEF}}, {4{32'h8000_0001}});
        idle();
        #1;
        check("R8 b not after one edge", {127'd0, out_valid_o}, 128'd0);
        @(negedge clk);
        #1;
        check("R8 b valid after two edges", {127'd0, out_valid_o}, 128'd1);

        // directed function cases
        send("R1 sigma only", 128'h0, 128'h0, {32'h0, 32'h1234_5678, 64'h0});
        send("R2 window splice", 128'h0, {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0BAD_0BAD},
             {96'h0, 32'h4444_4444});
        send("R3 upper source words", 128'h0, 128'h0, {32'hF00D_0001, 32'h0000_8001, 64'h0});
        send("R5 wrap sums", {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}});
        send("R4 chain abc", {96'h0, 32'h6162_6380}, 128'h0, {32'h0000_0018, 96'h0});
        idle();
        repeat (4) @(negedge clk);
        #1;
        check("R4 abc schedule words 16..19", held,
              {32'h6000_03C6, 32'h7DA8_6405, 32'h000F_0000, 32'h6162_6380});

        // random stream with backpressure
        bp_en = 1'b1;
        for (int k = 0; k < 60; k++) begin
            logic [127:0] a, b, c;
            for (int j = 0; j < 4; j++) begin
                step_lfsr(); a[j*32 +: 32] = lfsr;
                step_lfsr(); b[j*32 +: 32] = lfsr;
                step_lfsr(); c[j*32 +: 32] = lfsr ^ 32'h5A5A_0F0F;
            end
            send("R9 stream", a, b, c);
            if (lfsr[5]) idle();
        end
        idle();
        bp_en = 1'b0;
        repeat (10) @(negedge clk);
        #2;
        check("R9 all results delivered once", {64'(got), 64'(exp_q.size())}, {64'(sent), 64'd0});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule